// File: doc/BRIEF.md
# Parallel Port Input Handshake Controller

This block receives bytes from a host over a byte-wide parallel interface with an active-low strobe. It takes the host's strobe into the system clock domain and captures the data byte when the strobe goes low. It then raises a hardware busy flag without any CPU involvement. A firmware control bit chooses whether that flag rises on the strobe's falling edge or on its rising edge. The CPU reads the captured byte and the flag through a small four-register bus. It releases the host either by reading the data register or by writing an acknowledge register.

The busy line toward the host is the OR of the hardware flag and a busy bit that firmware writes, so firmware can hold the host off on its own. The block has two active-low clear inputs, a system reset and an init line. Either one returns the handshake to its empty state and loads the control register with its init values: firmware busy high, paper-end low and three lamp outputs high. A reset output shows that either clear input is active.

Top module: `pport_rx_ctrl`

## Requirements
- R1: The strobe passes through a two-flop synchronizer and is edge-detected. When the strobe is driven low ahead of rising clock edge k (leading-edge mode), the hardware busy flag is still 0 after edge k+1 and is 1 after edge k+2.
- R2: On every synchronized falling strobe edge the byte on `host_data` is stored. A read at address 0 returns the stored byte.
- R3: When control bit 0 is 0 (leading-edge mode), the hardware busy flag is set by the falling strobe edge.
- R4: When control bit 0 is 1 (trailing-edge mode), the falling strobe edge leaves the hardware busy flag clear. The rising strobe edge that follows sets it, two clock edges after the rising edge is synchronized.
- R5: A read at address 1 returns the hardware busy flag in bit 7 and zeros in bits 6..0.
- R6: A read at address 0, or any write at address 2, clears the hardware busy flag. If that clear falls in the same cycle as a leading-edge set, the flag stays set.
- R7: A write at address 1 loads the control register: bit 0 edge mode, bit 1 firmware busy, bit 2 paper-end, bits 5..3 lamps. A read at address 2 returns it with bits 7..6 zero. Address 3 reads 0, and writes to it have no effect.
- R8: `host_busy` equals the hardware busy flag ORed with the firmware busy bit.
- R9: While `rst_n` or `init_n` is low at a clock edge, the following are loaded: hardware busy 0, stored byte 0, edge mode 0, firmware busy 1, paper-end 0, lamps 3'b111.
- R10: `reset_out_n` is low exactly when `rst_n` or `init_n` is low.
- R11: A new falling strobe edge while the flag is set replaces the stored byte and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, synchronous |
| init_n | input | 1 | Init request, active low, synchronous |
| host_strobe_n | input | 1 | Host data strobe, active low, asynchronous |
| host_data | input | 8 | Host data byte, stable while the strobe is low |
| host_busy | output | 1 | Busy toward the host |
| reset_out_n | output | 1 | Combined clear, active low |
| paper_end | output | 1 | Paper-end indication from the control register |
| lamp | output | 3 | Lamp outputs from the control register |
| cpu_sel | input | 1 | Bus access strobe for this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational, 0 when not reading |

## Verification
The hardest case to reach from the ports is a CPU clear landing in the one cycle where the synchronized falling edge is active. A random bus access almost never lines up with that cycle. A directed sequence drives the strobe low on a falling clock edge and places an acknowledge write exactly two falling edges later. That is the cycle the synchronizer delay puts the edge event in. The bench repeats the case with a data-register read in the same slot. Random traffic with a fixed seed then mixes byte arrivals in both edge modes, clears, status reads and control writes against a bench-side model.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int LAMP_N  = 3;

  localparam logic [ADDR_W-1:0] A_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] A_STCTL = 2'd1;
  localparam logic [ADDR_W-1:0] A_ACK   = 2'd2;

  typedef enum logic [1:0] {RX_EMPTY = 2'd0, RX_ARMED = 2'd1, RX_FULL = 2'd2} rx_state_t;

  typedef struct packed {
    logic [LAMP_N-1:0] lamps;
    logic              pe;
    logic              fw_busy;
    logic              trail;
  } ctrl_t;

  localparam ctrl_t CTRL_INIT = '{lamps: '1, pe: 1'b0, fw_busy: 1'b1, trail: 1'b0};

  // Next handshake state: set events outrank clears.
  function automatic rx_state_t rx_next(rx_state_t cur, logic fall, logic rise,
                                        logic trail, logic clr);
    rx_state_t nxt;
    nxt = cur;
    case (cur)
      RX_EMPTY: if (fall) nxt = trail ? RX_ARMED : RX_FULL;
      RX_ARMED: if (rise) nxt = RX_FULL;
      RX_FULL: begin
        if (fall && clr)  nxt = trail ? RX_ARMED : RX_FULL;
        else if (clr)     nxt = RX_EMPTY;
      end
      default: nxt = RX_EMPTY;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/pport_strobe_sync.sv
module pport_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  input  logic strobe_n,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int CHAIN = STAGES + 1;
  logic [CHAIN-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk)
          if (!clr_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= strobe_n;
      end else begin : g_next
        always_ff @(posedge clk)
          if (!clr_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign fall_evt = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];
  assign rise_evt = ~chain_q[CHAIN-1] & chain_q[CHAIN-2];
endmodule

// File: rtl/pport_rx_fsm.sv
module pport_rx_fsm
  import pport_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic fall_evt,
  input  logic rise_evt,
  input  logic trail,
  input  logic clr_evt,
  output logic hw_busy
);
  rx_state_t st_q;

  always_ff @(posedge clk)
    if (!clr_n) st_q <= RX_EMPTY;
    else        st_q <= rx_next(st_q, fall_evt, rise_evt, trail, clr_evt);

  assign hw_busy = (st_q == RX_FULL);

  assert_lead_set_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (fall_evt && !trail) |=> hw_busy);
  assert_trail_hold_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (fall_evt && trail && !hw_busy) |=> !hw_busy);
  assert_trail_set_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (rise_evt && st_q == RX_ARMED) |=> hw_busy);
  assert_clear_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (clr_evt && !fall_evt && !rise_evt) |=> !hw_busy);
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              clr_n,
  input  logic              init_n,
  input  logic              rst_n,
  input  logic              fall_evt,
  input  logic [DATA_W-1:0] host_data,
  input  logic              hw_busy,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              clr_evt,
  output ctrl_t             ctrl
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] data_q;
  ctrl_t             ctrl_q;
  logic              rd_en, wr_en;

  assign rd_en   = cpu_sel & ~cpu_wr;
  assign wr_en   = cpu_sel &  cpu_wr;
  assign clr_evt = (rd_en && cpu_addr == A_DATA) || (wr_en && cpu_addr == A_ACK);

  always_ff @(posedge clk)
    if (!clr_n)        data_q <= '0;
    else if (fall_evt) data_q <= host_data;

  always_ff @(posedge clk)
    if (!clr_n)                              ctrl_q <= CTRL_INIT;
    else if (wr_en && cpu_addr == A_STCTL)   ctrl_q <= ctrl_t'(cpu_wdata[CTRL_W-1:0]);

  always_comb begin
    cpu_rdata = '0;
    if (rd_en) begin
      case (cpu_addr)
        A_DATA:  cpu_rdata = data_q;
        A_STCTL: cpu_rdata = {hw_busy, {(DATA_W-1){1'b0}}};
        A_ACK:   cpu_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        default: cpu_rdata = '0;
      endcase
    end
  end

  assign ctrl = ctrl_q;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!clr_n)
    fall_evt |=> data_q == $past(host_data));
  assert_init_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !init_n |=> (ctrl_q == CTRL_INIT && data_q == '0));
endmodule

// File: rtl/pport_rx_ctrl.sv
module pport_rx_ctrl
  import pport_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_n,
  input  logic                host_strobe_n,
  input  logic [DATA_W-1:0]   host_data,
  output logic                host_busy,
  output logic                reset_out_n,
  output logic                paper_end,
  output logic [LAMP_N-1:0]   lamp,
  input  logic                cpu_sel,
  input  logic                cpu_wr,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata
);
  logic  clr_n, fall_evt, rise_evt, clr_evt, hw_busy;
  ctrl_t ctrl;

  assign clr_n       = rst_n & init_n;
  assign reset_out_n = clr_n;

  pport_strobe_sync #(.STAGES(2)) u_sync (
    .clk(clk), .clr_n(clr_n), .strobe_n(host_strobe_n),
    .fall_evt(fall_evt), .rise_evt(rise_evt));

  pport_rx_fsm u_fsm (
    .clk(clk), .clr_n(clr_n), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .trail(ctrl.trail), .clr_evt(clr_evt), .hw_busy(hw_busy));

  pport_regs u_regs (
    .clk(clk), .clr_n(clr_n), .init_n(init_n), .rst_n(rst_n),
    .fall_evt(fall_evt), .host_data(host_data), .hw_busy(hw_busy),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .clr_evt(clr_evt), .ctrl(ctrl));

  assign host_busy = hw_busy | ctrl.fw_busy;
  assign paper_end = ctrl.pe;
  assign lamp      = ctrl.lamps;

  assert_fw_busy_R8: assert property (@(posedge clk) disable iff (!clr_n)
    (cpu_sel && cpu_wr && cpu_addr == A_STCTL && cpu_wdata[1]) |=> host_busy);
  assert_single_evt_R1: assert property (@(posedge clk) disable iff (!clr_n)
    fall_evt |=> !fall_evt);
endmodule

// File: tb/pport_rx_ctrl_test.sv
module pport_rx_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0, init_n = 1'b1, strobe_n = 1'b1;
  logic [7:0] hdata = 8'h00;
  logic busy, rout_n, pe;
  logic [2:0] lamp;
  logic sel = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic       m_hw;
  logic [7:0] m_data;
  logic [5:0] m_ctrl;

  always #4 clk = ~clk;

  pport_rx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .host_strobe_n(strobe_n),
    .host_data(hdata), .host_busy(busy), .reset_out_n(rout_n), .paper_end(pe),
    .lamp(lamp), .cpu_sel(sel), .cpu_wr(wr), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rdata));

  function automatic logic [7:0] status_of(logic hw);
    return {hw, 7'b0};
  endfunction

  function automatic logic host_busy_of(logic hw, logic [5:0] c);
    return hw | c[1];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic set_ctrl(logic [5:0] c);
    bus_wr(2'd1, {2'b00, c});
    m_ctrl = c;
  endtask

  task automatic send_byte(logic [7:0] b);
    logic [7:0] d;
    hdata = b;
    @(negedge clk); strobe_n = 1'b0;
    cyc(5);
    if (!m_ctrl[0]) m_hw = 1'b1;
    m_data = b;
    bus_rd(2'd1, d);
    check(m_ctrl[0] ? "R4 lead-phase status" : "R3 lead-phase status", d, status_of(m_hw));
    @(negedge clk); strobe_n = 1'b1;
    cyc(5);
    m_hw = 1'b1;
    check("R8 host_busy after byte", busy, host_busy_of(m_hw, m_ctrl));
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1D5E_ED01));
    m_hw = 1'b0; m_data = 8'h00; m_ctrl = 6'b111_0_1_0;
    cyc(1);
    check("R10 reset_out_n in reset", rout_n, 1'b0);
    cyc(2); rst_n = 1'b1; cyc(1);
    check("R10 reset_out_n released", rout_n, 1'b1);
    check("R9 firmware busy after reset", busy, 1'b1);
    check("R9 lamps after reset", lamp, 3'b111);
    check("R9 paper_end after reset", pe, 1'b0);
    bus_rd(2'd2, d); check("R9 ctrl readback", d, 8'h3A);
    bus_rd(2'd0, d); check("R9 data after reset", d, 8'h00);

    set_ctrl(6'b000_0_0_0);
    check("R8 busy low with both clear", busy, 1'b0);

    // R1 exact latency from strobe low
    hdata = 8'hA5;
    @(negedge clk); strobe_n = 1'b0;
    cyc(2); check("R1 busy not yet set", busy, 1'b0);
    cyc(1); check("R1 busy set on third edge", busy, 1'b1);
    m_hw = 1'b1; m_data = 8'hA5;
    @(negedge clk); strobe_n = 1'b1; cyc(4);
    bus_rd(2'd1, d); check("R5 status busy", d, 8'h80);
    bus_rd(2'd0, d); check("R2 data read", d, 8'hA5);
    m_hw = 1'b0;
    bus_rd(2'd1, d); check("R6 read clears busy", d, 8'h00);

    // R11 overwrite while full
    send_byte(8'h3C); send_byte(8'hC3);
    bus_rd(2'd0, d); check("R11 overwrite data", d, 8'hC3);
    m_hw = 1'b0;

    // R4 trailing mode latency
    set_ctrl(6'b000_0_0_1);
    hdata = 8'h5A;
    @(negedge clk); strobe_n = 1'b0; cyc(6);
    check("R4 no busy on leading", busy, 1'b0);
    @(negedge clk); strobe_n = 1'b1;
    cyc(2); check("R4 busy not yet on trailing", busy, 1'b0);
    cyc(1); check("R4 busy after trailing", busy, 1'b1);
    bus_wr(2'd2, 8'h00);
    check("R6 ack write clears", busy, 1'b0);
    bus_rd(2'd0, d); check("R2 data trailing mode", d, 8'h5A);
    set_ctrl(6'b000_0_0_0);

    // R6 clear coinciding with set: ack write, then data read
    for (int k = 0; k < 2; k++) begin
      hdata = 8'h11 + 8'(k);
      @(negedge clk); strobe_n = 1'b0;
      cyc(1);
      @(negedge clk); sel = 1'b1; wr = (k == 0); addr = (k == 0) ? 2'd2 : 2'd0;
      @(negedge clk); sel = 1'b0; wr = 1'b0;
      check("R6 set wins over clear", busy, 1'b1);
      @(negedge clk); strobe_n = 1'b1; cyc(4);
      bus_wr(2'd2, 8'h00);
    end
    m_hw = 1'b0;

    // R7 address 3
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, d); check("R7 addr3 reads zero", d, 8'h00);
    bus_rd(2'd2, d); check("R7 addr3 write ignored", d, 8'h00);
    check("R7 addr3 write no busy", busy, 1'b0);

    // R9 init clears handshake and control
    set_ctrl(6'b010_1_0_1);
    send_byte(8'h77);
    init_n = 1'b0; #1 check("R10 reset_out_n on init", rout_n, 1'b0);
    cyc(2); init_n = 1'b1; cyc(1);
    m_hw = 1'b0; m_data = 8'h00; m_ctrl = 6'b111_0_1_0;
    bus_rd(2'd1, d); check("R9 init clears hw busy", d, 8'h00);
    bus_rd(2'd0, d); check("R9 init clears data", d, 8'h00);
    check("R9 init lamps", lamp, 3'b111);
    check("R9 init paper_end", pe, 1'b0);
    check("R9 init fw busy", busy, 1'b1);

    // random traffic
    for (int i = 0; i < 200; i++) begin
      case ($urandom % 5)
        0: send_byte(8'($urandom));
        1: begin bus_rd(2'd0, d); check("R2 random data", d, m_data); m_hw = 1'b0; end
        2: begin bus_wr(2'd2, 8'($urandom)); m_hw = 1'b0; end
        3: begin bus_rd(2'd1, d); check("R5 random status", d, status_of(m_hw)); end
        default: begin
          set_ctrl(6'($urandom));
          check("R7 paper_end", pe, m_ctrl[2]);
          check("R7 lamps", lamp, m_ctrl[5:3]);
          bus_rd(2'd2, d); check("R7 ctrl readback", d, {2'b00, m_ctrl});
        end
      endcase
      check("R8 host_busy random", busy, host_busy_of(m_hw, m_ctrl));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule